// File: doc/BRIEF.md
# Strobe-Multiplexed Address Rebuilder for Static RAM

This block sits between a memory controller built for dynamic RAM and a byte-wide static RAM of 512K locations. The controller time-shares one narrow address bus. It first drives the row half and pulls the active-low row strobe low. It then drives the column half and pulls the active-low column strobe low. The rebuilder samples both strobes with a fast local clock. It finds their falling edges and stores each half in an edge-loaded register. After that it presents the full address and the static RAM control lines.

Each half is stored only at the moment its strobe falls, so the bus is free to change afterwards. The most significant address bit comes from a bank-select input, which is stored together with the row. The static RAM is enabled only after the column has been taken, and it stays enabled until the row strobe rises. A controller write-request level chooses between a write-enable and an output-enable pulse. A column strobe that falls while no row cycle is open is a refresh-style cycle: the block ignores it and keeps the stored address.

Top module: `dram_sram_bridge`

## Requirements
- R1: On a falling row strobe with the column strobe high, the upper address bits sram_addr[18:9] take {bank_sel, mux_addr} as sampled with that edge.
- R2: On a falling column strobe while a row is open, the low address bits sram_addr[8:0] take mux_addr as sampled with that edge.
- R3: Changes on mux_addr or bank_sel after a strobe edge leave sram_addr unchanged.
- R4: sram_ce_n (active low) stays high after a row capture alone and goes low only after the column capture.
- R5: sram_ce_n returns high once the row strobe rises, and sram_addr keeps its last value.
- R6: While sram_ce_n is low, wr_req=1 gives sram_we_n=0 and sram_oe_n=1, and wr_req=0 gives sram_oe_n=0 and sram_we_n=1. With sram_ce_n high, both stay high.
- R7: A column strobe that falls before the row strobe leaves sram_ce_n high and sram_addr unchanged until both strobes are back high.
- R8: A further falling column strobe while the row strobe stays low reloads sram_addr[8:0], and sram_ce_n stays low.
- R9: While rst_n is low, sram_addr is zero and sram_ce_n, sram_oe_n and sram_we_n are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock, faster than the strobe timing |
| rst_n | input | 1 | Asynchronous active-low reset |
| mux_addr | input | 9 | Time-shared row/column address bus |
| row_stb_n | input | 1 | Active-low row strobe |
| col_stb_n | input | 1 | Active-low column strobe |
| bank_sel | input | 1 | Top address bit, stored with the row |
| wr_req | input | 1 | 1 = write cycle, 0 = read cycle |
| sram_addr | output | 19 | Rebuilt static RAM address {bank, row, column} |
| sram_ce_n | output | 1 | Static RAM chip enable, active low |
| sram_oe_n | output | 1 | Static RAM output enable, active low |
| sram_we_n | output | 1 | Static RAM write enable, active low |

## Verification
The bench builds the block with the defaults: a 9-bit half width and two synchronizer stages. With these values the full 19-bit address, including the bank bit, is in reach, and every strobe edge reaches the outputs three clock edges after the bus changes. Each table entry puts a different bit pattern in the bank, row and column fields and then scrambles the bus after every strobe edge. The directed tests open a page-mode burst, send a column strobe ahead of the row strobe, and assert reset in the middle of an active cycle.

// File: rtl/bridge_pkg.sv
package bridge_pkg;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ROW     = 2'd1,
        ST_ACTIVE  = 2'd2,
        ST_REFRESH = 2'd3
    } bridge_state_e;

    typedef struct packed {
        bridge_state_e state;
        logic          ce_n;
        logic          oe_n;
        logic          we_n;
    } ctrl_regs_t;

endpackage

// File: rtl/input_sync.sv
module input_sync #(
    parameter int          W       = 4,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic [W-1:0] dprev
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] pipe;
        logic [W-1:0]             prev;
    } sync_regs_t;

    sync_regs_t s_d, s_q;

    always_comb begin
        s_d         = s_q;
        s_d.pipe[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            s_d.pipe[i] = s_q.pipe[i-1];
        end
        s_d.prev = s_q.pipe[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.pipe <= {STAGES{RST_VAL}};
            s_q.prev <= RST_VAL;
        end else begin
            s_q <= s_d;
        end
    end

    assign dout  = s_q.pipe[STAGES-1];
    assign dprev = s_q.prev;
endmodule

// File: rtl/half_latch.sv
module half_latch #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (load) begin
            val_d = d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            val_q <= '0;
        end else begin
            val_q <= val_d;
        end
    end

    assign q = val_q;
endmodule

// File: rtl/cycle_ctrl.sv
module cycle_ctrl
    import bridge_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic row_lvl,
    input  logic row_prev,
    input  logic col_lvl,
    input  logic col_prev,
    input  logic wr_lvl,
    output logic load_row,
    output logic load_col,
    output logic ce_n,
    output logic oe_n,
    output logic we_n
);
    ctrl_regs_t c_d, c_q;
    logic row_fall, row_rise, col_fall;

    always_comb begin
        row_fall = row_prev & ~row_lvl;
        row_rise = ~row_prev & row_lvl;
        col_fall = col_prev & ~col_lvl;
        c_d      = c_q;
        load_row = 1'b0;
        load_col = 1'b0;
        case (c_q.state)
            ST_IDLE: begin
                if (!col_lvl) begin
                    c_d.state = ST_REFRESH;
                end else if (row_fall) begin
                    c_d.state = ST_ROW;
                    load_row  = 1'b1;
                end
            end
            ST_ROW: begin
                if (row_rise) begin
                    c_d.state = ST_IDLE;
                end else if (col_fall) begin
                    c_d.state = ST_ACTIVE;
                    load_col  = 1'b1;
                end
            end
            ST_ACTIVE: begin
                if (row_rise) begin
                    c_d.state = ST_IDLE;
                end else if (col_fall) begin
                    load_col = 1'b1;
                end
            end
            default: begin
                if (row_lvl && col_lvl) begin
                    c_d.state = ST_IDLE;
                end
            end
        endcase
        c_d.ce_n = (c_d.state != ST_ACTIVE);
        c_d.oe_n = c_d.ce_n | wr_lvl;
        c_d.we_n = c_d.ce_n | ~wr_lvl;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q.state <= ST_IDLE;
            c_q.ce_n  <= 1'b1;
            c_q.oe_n  <= 1'b1;
            c_q.we_n  <= 1'b1;
        end else begin
            c_q <= c_d;
        end
    end

    assign ce_n = c_q.ce_n;
    assign oe_n = c_q.oe_n;
    assign we_n = c_q.we_n;
endmodule

// File: rtl/dram_sram_bridge.sv
module dram_sram_bridge #(
    parameter int HALF_W      = 9,
    parameter int SYNC_STAGES = 2,
    localparam int ADDR_W     = 2 * HALF_W + 1,
    localparam int BUS_W      = HALF_W + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] mux_addr,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic              bank_sel,
    input  logic              wr_req,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_ce_n,
    output logic              sram_oe_n,
    output logic              sram_we_n
);
    localparam int P_BANK = HALF_W;
    localparam int P_WR   = HALF_W + 1;
    localparam int P_COL  = HALF_W + 2;
    localparam int P_ROW  = HALF_W + 3;
    localparam logic [BUS_W-1:0] IDLE_VAL = {2'b11, {(HALF_W+2){1'b0}}};

    logic [BUS_W-1:0]  bus_in, bus_now, bus_prev;
    logic              row_lvl, col_lvl, load_row, load_col;
    logic [HALF_W:0]   row_q;
    logic [HALF_W-1:0] col_q;

    assign bus_in = {row_stb_n, col_stb_n, wr_req, bank_sel, mux_addr};

    input_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL(IDLE_VAL)) u_sync (
        .clk(clk), .rst_n(rst_n), .din(bus_in), .dout(bus_now), .dprev(bus_prev)
    );

    assign row_lvl = bus_now[P_ROW];
    assign col_lvl = bus_now[P_COL];

    cycle_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .row_lvl(row_lvl), .row_prev(bus_prev[P_ROW]),
        .col_lvl(col_lvl), .col_prev(bus_prev[P_COL]),
        .wr_lvl(bus_now[P_WR]),
        .load_row(load_row), .load_col(load_col),
        .ce_n(sram_ce_n), .oe_n(sram_oe_n), .we_n(sram_we_n)
    );

    half_latch #(.W(HALF_W + 1)) u_row (
        .clk(clk), .rst_n(rst_n), .load(load_row),
        .d({bus_now[P_BANK], bus_now[HALF_W-1:0]}), .q(row_q)
    );

    half_latch #(.W(HALF_W)) u_col (
        .clk(clk), .rst_n(rst_n), .load(load_col),
        .d(bus_now[HALF_W-1:0]), .q(col_q)
    );

    assign sram_addr = {row_q, col_q};
endmodule

// File: rtl/bridge_checks.sv
module bridge_checks #(
    parameter int HALF_W = 9,
    localparam int ADDR_W = 2 * HALF_W + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] sram_addr,
    input logic              sram_ce_n,
    input logic              sram_oe_n,
    input logic              sram_we_n,
    input logic              load_row,
    input logic              load_col,
    input logic              row_lvl
);
    p_row_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr[ADDR_W-1:HALF_W]) |-> $past(load_row));

    p_col_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sram_addr[HALF_W-1:0]) |-> $past(load_col));

    p_ce_after_col_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sram_ce_n) |-> $past(load_col));

    p_ce_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sram_ce_n) |-> $past(row_lvl));

    p_we_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_we_n |-> (!sram_ce_n && sram_oe_n));

    p_oe_qual_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sram_oe_n |-> (!sram_ce_n && sram_we_n));

    p_reset_idle_r9: assert property (@(posedge clk)
        !rst_n |=> (sram_ce_n && sram_oe_n && sram_we_n));
endmodule

bind dram_sram_bridge bridge_checks #(.HALF_W(HALF_W)) u_checks (
    .clk(clk), .rst_n(rst_n), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .load_row(load_row), .load_col(load_col), .row_lvl(row_lvl)
);

// File: tb/tb_dram_sram_bridge.sv
`timescale 1ns/1ps
module tb_dram_sram_bridge;
    localparam int HW = 9;
    localparam int AW = 2 * HW + 1;
    localparam int SETTLE = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [HW-1:0] mux_addr = '0;
    logic          row_stb_n = 1'b1, col_stb_n = 1'b1, bank_sel = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] sram_addr;
    logic          sram_ce_n, sram_oe_n, sram_we_n;
    int            errors = 0, checks = 0;
    bit            done = 1'b0;

    // entry: {bank, row, col, wr}
    localparam logic [19:0] VEC [6] = '{
        {1'b1, 9'h1A5, 9'h0C3, 1'b0},
        {1'b0, 9'h000, 9'h1FF, 1'b1},
        {1'b1, 9'h1FF, 9'h000, 1'b1},
        {1'b0, 9'h155, 9'h0AA, 1'b0},
        {1'b1, 9'h0AA, 9'h155, 1'b1},
        {1'b0, 9'h001, 9'h100, 1'b0}
    };

    always #2 clk = ~clk;

    dram_sram_bridge dut (
        .clk(clk), .rst_n(rst_n), .mux_addr(mux_addr),
        .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .bank_sel(bank_sel), .wr_req(wr_req),
        .sram_addr(sram_addr), .sram_ce_n(sram_ce_n),
        .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (SETTLE) @(negedge clk);
    endtask

    task automatic open_row(input logic b, input logic [HW-1:0] r);
        mux_addr = r; bank_sel = b; row_stb_n = 1'b0;
        settle();
        mux_addr = ~r; bank_sel = ~b;
        settle();
    endtask

    task automatic take_col(input logic [HW-1:0] c);
        mux_addr = c; col_stb_n = 1'b0;
        settle();
        mux_addr = ~c;
        settle();
    endtask

    task automatic close_all();
        col_stb_n = 1'b1; row_stb_n = 1'b1;
        settle();
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        chk("R9 reset addr", 32'(sram_addr), 32'h0);
        chk("R9 reset ctrl", {29'h0, sram_ce_n, sram_oe_n, sram_we_n}, 32'h7);
        rst_n = 1'b1;
        settle();

        foreach (VEC[i]) begin
            logic b; logic [HW-1:0] r, c; logic w;
            {b, r, c, w} = VEC[i];
            wr_req = w;
            open_row(b, r);
            chk("R1 row bits", 32'(sram_addr[AW-1:HW]), 32'({b, r}));
            chk("R4 ce after row only", 32'(sram_ce_n), 32'h1);
            take_col(c);
            chk("R2/R3 full addr", 32'(sram_addr), 32'({b, r, c}));
            chk("R4 ce after col", 32'(sram_ce_n), 32'h0);
            chk("R6 we_n", 32'(sram_we_n), 32'(!w));
            chk("R6 oe_n", 32'(sram_oe_n), 32'(w));
            close_all();
            chk("R5 ce released", {29'h0, sram_ce_n, sram_oe_n, sram_we_n}, 32'h7);
            chk("R5 addr held", 32'(sram_addr), 32'({b, r, c}));
        end

        // refresh-style: column strobe first
        begin
            logic [AW-1:0] held;
            held = sram_addr;
            mux_addr = 9'h033; col_stb_n = 1'b0;
            settle();
            mux_addr = 9'h0F0; bank_sel = 1'b1; row_stb_n = 1'b0;
            settle();
            chk("R7 refresh no enable", 32'(sram_ce_n), 32'h1);
            chk("R7 refresh addr", 32'(sram_addr), 32'(held));
            close_all();
        end

        // page mode: second column while row stays low
        wr_req = 1'b0;
        open_row(1'b0, 9'h0F0);
        take_col(9'h011);
        chk("R8 first col", 32'(sram_addr), 32'({1'b0, 9'h0F0, 9'h011}));
        col_stb_n = 1'b1;
        settle();
        chk("R8 ce held between columns", 32'(sram_ce_n), 32'h0);
        take_col(9'h1EE);
        chk("R8 second col", 32'(sram_addr), 32'({1'b0, 9'h0F0, 9'h1EE}));
        chk("R8 ce still low", 32'(sram_ce_n), 32'h0);

        // reset during an active cycle
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 mid-cycle reset addr", 32'(sram_addr), 32'h0);
        chk("R9 mid-cycle reset ctrl", {29'h0, sram_ce_n, sram_oe_n, sram_we_n}, 32'h7);
        close_all();
        rst_n = 1'b1;
        settle();

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule